// File: doc/BRIEF.md
# CAN Fault Confinement Counter

This block holds the two error counters of a CAN node, one for transmit and one for receive, and reports the node's fault-confinement state. The protocol engine feeds it four single-cycle event pulses: a transmit error, a receive error, a successful transmission and a successful reception. From these the block steps the counters with asymmetric weights. A transmit error counts heavily, while a receive error and either kind of success count by one.

The state follows from the two counter values. While both counters are low the node is error active and signals errors with dominant flag bits. Once either counter reaches the passive threshold, the node becomes error passive and its flags turn recessive. When the transmit counter climbs past the bus-off limit, the node stops driving the bus. It stays in that state until a recover pulse clears both counters. A restricted-operation input freezes both counters while the node keeps running.

Top module: `can_fault_confine`

## Requirements
- R1: A pulse on `tx_err_i` raises `tec_o` by 8 on the next clock edge, unless the node is frozen (see R7, R8) or recovering (see R9).
- R2: A pulse on `rx_err_i` raises `rec_o` by 1 on the next clock edge. `rec_o` saturates at 255 and never wraps.
- R3: A pulse on `tx_ok_i` or `rx_ok_i` lowers the matching counter by 1. A counter at zero stays at zero.
- R4: When an error pulse and a success pulse reach the same counter in one cycle, the error step is applied and the success pulse is ignored.
- R5: When both counters are below 128, `state_o` is 2'b00 (error active), `flag_recessive_o` is 0 and `flag_enable_o` is 1.
- R6: When either counter is 128 or more and `tec_o` is 255 or less, `state_o` is 2'b01 (error passive), `flag_recessive_o` is 1 and `flag_enable_o` is 1.
- R7: When `tec_o` exceeds 255, `state_o` is 2'b10 (bus-off), `flag_enable_o` is 0 and `flag_recessive_o` is 0. All four event pulses are ignored until a recover pulse arrives, so bus-off persists.
- R8: While `restrict_i` is high, all four event pulses leave both counters unchanged.
- R9: A pulse on `recover_i` clears both counters on the next edge. It takes priority over every event pulse and over `restrict_i`.
- R10: After reset both counters read zero and the state is error active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| restrict_i | input | 1 | Restricted operation: counters frozen |
| recover_i | input | 1 | Clears both counters and leaves bus-off |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | 00 active, 01 passive, 10 bus-off |
| flag_recessive_o | output | 1 | Error flag uses recessive bits |
| flag_enable_o | output | 1 | Node may send an error flag |

## Verification
The assertions check on every cycle the per-counter stepping rules. These are the +8 and +1 steps, saturation, the floor at zero, the freeze under restriction or bus-off, the clear on recover, and the persistence of bus-off.

The bench's scenarios are needed for the rest. They cover the threshold crossings into passive and bus-off and the mapping to flag polarity. They also cover the priority of an error over a success in the same cycle, and long sequences where the two counters interact through the shared bus-off freeze. A reference model in the bench follows every cycle of a seeded random run and of the directed corner cases.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_state_e;

endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
   parameter int W        = 8,
   parameter int STEP     = 1,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         hold,
   input  logic         err,
   input  logic         ok,
   output logic [W-1:0] cnt
);

   localparam int         MAXV   = (1 << W) - 1;
   localparam logic [W:0] STEP_X = (W+1)'(STEP);

   if (W < 2 || W > 16) begin : g_bad_width
      $error("can_fc_counter: W out of range");
   end
   if (STEP < 1 || STEP >= MAXV) begin : g_bad_step
      $error("can_fc_counter: STEP must be between 1 and 2**W-2");
   end

   logic [W:0]   sum;
   logic [W-1:0] up_val;
   logic [W-1:0] down_val;

   assign sum      = {1'b0, cnt} + STEP_X;
   assign down_val = (cnt == '0) ? '0 : cnt - 1'b1;

   if (SATURATE) begin : g_sat
      assign up_val = sum[W] ? {W{1'b1}} : sum[W-1:0];
   end else begin : g_wrap
      assign up_val = sum[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (!hold) begin
         if (err)      cnt <= up_val;
         else if (ok)  cnt <= down_val;
      end
   end

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !hold && err && !sum[W]) |=> (cnt == $past(cnt) + W'(STEP))); // R1 R2

   if (SATURATE) begin : g_sat_chk
      AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && !hold && err && sum[W]) |=> (cnt == {W{1'b1}})); // R2
   end

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !hold && !err && ok && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3 R4

   AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !err && cnt == '0) |=> (cnt == '0)); // R3

   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && hold) |=> $stable(cnt)); // R7 R8

   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R9

endmodule

// File: rtl/can_fc_state_map.sv
module can_fc_state_map
   import can_fc_pkg::*;
#(
   parameter int TEC_W       = 9,
   parameter int REC_W       = 8,
   parameter int PASSIVE_LIM = 128,
   parameter int BUSOFF_LIM  = 256
) (
   input  logic [TEC_W-1:0] tec,
   input  logic [REC_W-1:0] rec,
   output fc_state_e        state,
   output logic             flag_recessive,
   output logic             flag_enable
);

   if (BUSOFF_LIM >= (1 << TEC_W)) begin : g_bad_busoff
      $error("can_fc_state_map: transmit counter too narrow for bus-off limit");
   end
   if (PASSIVE_LIM >= BUSOFF_LIM || PASSIVE_LIM < 1) begin : g_bad_passive
      $error("can_fc_state_map: passive limit must lie below bus-off limit");
   end

   logic tec_busoff;
   logic any_passive;

   assign tec_busoff  = (32'(tec) >= BUSOFF_LIM);
   assign any_passive = (32'(tec) >= PASSIVE_LIM) || (32'(rec) >= PASSIVE_LIM);

   always_comb begin
      if (tec_busoff)       state = FC_BUSOFF;
      else if (any_passive) state = FC_PASSIVE;
      else                  state = FC_ACTIVE;
   end

   assign flag_recessive = (state == FC_PASSIVE);
   assign flag_enable    = (state != FC_BUSOFF);

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
   import can_fc_pkg::*;
#(
   parameter int TEC_W       = 9,
   parameter int REC_W       = 8,
   parameter int TX_STEP     = 8,
   parameter int RX_STEP     = 1,
   parameter int PASSIVE_LIM = 128,
   parameter int BUSOFF_LIM  = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_err_i,
   input  logic             rx_err_i,
   input  logic             tx_ok_i,
   input  logic             rx_ok_i,
   input  logic             restrict_i,
   input  logic             recover_i,
   output logic [TEC_W-1:0] tec_o,
   output logic [REC_W-1:0] rec_o,
   output logic [1:0]       state_o,
   output logic             flag_recessive_o,
   output logic             flag_enable_o
);

   fc_state_e state;
   logic      bus_off;
   logic      freeze;

   assign bus_off = (state == FC_BUSOFF);
   assign freeze  = restrict_i | bus_off;

   can_fc_counter #(.W(TEC_W), .STEP(TX_STEP), .SATURATE(1'b1)) u_tec (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (recover_i),
      .hold (freeze),
      .err  (tx_err_i),
      .ok   (tx_ok_i),
      .cnt  (tec_o)
   );

   can_fc_counter #(.W(REC_W), .STEP(RX_STEP), .SATURATE(1'b1)) u_rec (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (recover_i),
      .hold (freeze),
      .err  (rx_err_i),
      .ok   (rx_ok_i),
      .cnt  (rec_o)
   );

   can_fc_state_map #(
      .TEC_W(TEC_W), .REC_W(REC_W),
      .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
   ) u_map (
      .tec           (tec_o),
      .rec           (rec_o),
      .state         (state),
      .flag_recessive(flag_recessive_o),
      .flag_enable   (flag_enable_o)
   );

   assign state_o = state;

   AST_BUSOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off && !recover_i) |=> (state_o == FC_BUSOFF)); // R7

   AST_RECOVER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      recover_i |=> (state_o == FC_ACTIVE && flag_enable_o)); // R9

   AST_BUSOFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == FC_BUSOFF) |-> (!flag_enable_o && !flag_recessive_o)); // R7

endmodule

// File: tb/can_fault_confine_test.sv
module can_fault_confine_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_err, rx_err, tx_ok, rx_ok, restr, recov;
   logic [8:0] tec;
   logic [7:0] rec;
   logic [1:0] state;
   logic       flag_rec, flag_en;

   int vectors = 0;
   int errors  = 0;
   int m_tec   = 0;
   int m_rec   = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_fault_confine uut (
      .clk(clk), .rst_n(rst_n),
      .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
      .restrict_i(restr), .recover_i(recov),
      .tec_o(tec), .rec_o(rec), .state_o(state),
      .flag_recessive_o(flag_rec), .flag_enable_o(flag_en)
   );

   function automatic int exp_state(int t, int r);
      if (t > 255) return 2;
      if (t >= 128 || r >= 128) return 1;
      return 0;
   endfunction

   task automatic check(string tag);
      int es;
      es = exp_state(m_tec, m_rec);
      vectors++;
      if (int'(tec) != m_tec || int'(rec) != m_rec || int'(state) != es ||
          flag_rec != (es == 1) || flag_en != (es != 2)) begin
         errors++;
         $display("FAIL %s: actual tec=%0d rec=%0d st=%0d frec=%0b fen=%0b expected tec=%0d rec=%0d st=%0d frec=%0b fen=%0b",
                  tag, tec, rec, state, flag_rec, flag_en,
                  m_tec, m_rec, es, es == 1, es != 2);
      end
   endtask

   task automatic step(bit te, bit re, bit to, bit ro, bit rs, bit rv);
      string tag;
      if (rv)                   tag = "R9";
      else if (m_tec > 255)     tag = "R7";
      else if (rs)              tag = "R8";
      else if ((te && to) || (re && ro)) tag = "R4";
      else if (te)              tag = "R1";
      else if (re)              tag = "R2";
      else if (to || ro)        tag = "R3";
      else if (exp_state(m_tec, m_rec) == 1) tag = "R6";
      else                      tag = "R5";
      @(negedge clk);
      tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; restr = rs; recov = rv;
      @(posedge clk);
      if (rv) begin
         m_tec = 0; m_rec = 0;
      end else if (!rs && m_tec <= 255) begin
         if (te)                   m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
         else if (to && m_tec > 0) m_tec = m_tec - 1;
         if (re)                   m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
         else if (ro && m_rec > 0) m_rec = m_rec - 1;
      end
      @(negedge clk);
      tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; restr = 0; recov = 0;
      check(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; restr = 0; recov = 0;
      repeat (3) @(negedge clk);
      check("R10");
      rst_n = 1'b1;
      @(negedge clk);
      check("R10");

      // R3: floor at zero
      step(0, 0, 1, 1, 0, 0);
      // R1: sixteen transmit errors reach the passive threshold (R6)
      for (int i = 0; i < 15; i++) step(1, 0, 0, 0, 0, 0);
      check("R5");
      step(1, 0, 0, 0, 0, 0);
      check("R6");
      // R4: error and success together
      step(1, 1, 1, 1, 0, 0);
      // R8: restricted mode freezes everything
      step(1, 1, 0, 0, 1, 0);
      step(0, 0, 1, 1, 1, 0);
      // R7: drive to bus-off, then events ignored
      for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0);
      check("R7");
      step(0, 0, 1, 1, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      check("R7");
      // R9: recover beats events
      step(1, 1, 0, 0, 1, 1);
      check("R9");
      // R2: receive counter saturates; passive from receive side (R6)
      for (int i = 0; i < 260; i++) step(0, 1, 0, 0, 0, 0);
      check("R2");
      step(0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 1);

      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         int w;
         w = $urandom_range(0, 99);
         step(w < 30, ($urandom_range(0, 99) < 45),
              ($urandom_range(0, 99) < 25), ($urandom_range(0, 99) < 35),
              ($urandom_range(0, 99) < 4), ($urandom_range(0, 999) < 3));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule